// File: doc/BRIEF.md
# Separate-IO Burst-of-Four SRAM Port

This block models a static memory with a dedicated read port and a dedicated write port. Every transfer on either port is a burst of four words. Commands and addresses are taken on the rising edge of a single clock. A burst moves two words per clock, carried as a low half-word and a high half-word, so each burst occupies two clock cycles on its port. The read port and the write port each sequence their own bursts. They can run at the same time without disturbing each other.

A read command loads a base address. The four words come from the base address and the next three addresses. Only the two low address bits step, so the sequence wraps inside an aligned group of four. The first pair of words appears in the cycle after the next clock edge, and the second pair follows one cycle later. A write command takes its first pair of words in the command cycle and the second pair in the next cycle. A read that overlaps a write to the same words returns the data being written. The storage is a register array inside the block.

Top module: `sio_burst4_sram`

## Requirements
- R1: A synchronous active-high reset drives rd_valid low and rd_lo/rd_hi to zero, and cancels any read or write burst in progress. A read command in the first cycle after reset is accepted.
- R2: If rd_n and wr_n are both high in a free command slot, no burst starts on either port and no storage location changes.
- R3: In the cycle right after a read command is loaded, rd_n and rd_addr are ignored. A new read can be loaded no sooner than two cycles after the previous one.
- R4: A read loaded at edge T gives rd_lo=word[A] and rd_hi=word[A+1] with rd_valid high after edge T+1, then rd_lo=word[A+2] and rd_hi=word[A+3] with rd_valid high after edge T+2. Reads issued every other cycle keep rd_valid high without a gap.
- R5: Burst address k (k=0..3) is formed as {A[upper], (A[1:0]+k) mod 4}. The carry never reaches the upper address bits.
- R6: A write loaded at edge T stores wr_lo and wr_hi into A and A+1 at edge T. At edge T+1 it stores wr_lo and wr_hi into A+2 and A+3. In that second cycle, wr_n and wr_addr are ignored.
- R7: A read burst and a write burst can be in progress in the same cycles, and each gives the same result it would give alone.
- R8: Read data for a word written at the same clock edge that captures the read data is the newly written value.
- R9: In any cycle with no read beat pair to deliver, rd_valid is low and rd_lo/rd_hi are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every input is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_n | input | 1 | Active-low read command |
| rd_addr | input | ADDR_W | Read burst base address |
| wr_n | input | 1 | Active-low write command |
| wr_addr | input | ADDR_W | Write burst base address |
| wr_lo | input | DATA_W | Write data, first word of the pair for this cycle |
| wr_hi | input | DATA_W | Write data, second word of the pair for this cycle |
| rd_lo | output | DATA_W | Read data, first word of the pair |
| rd_hi | output | DATA_W | Read data, second word of the pair |
| rd_valid | output | 1 | High while rd_lo/rd_hi carry a burst pair |

## Verification
Two events can fall on the same clock edge: a write storing words, and a read capturing words at the same addresses. This happens when a read head samples a write head, or a write tail, at that edge. The bench provokes it by issuing a read and a write on the same cycle or one cycle apart, with overlapping base addresses. A reference model applies that edge's writes before it forms the expected read pair, and so predicts forwarded data. A scoreboard compares every delivered pair with the model. It also flags any valid pair the model did not expect, which is how an ignored second read is judged.

// File: rtl/sio_burst4_pkg.sv
package sio_burst4_pkg;

   typedef enum logic [1:0] {
      RD_IDLE   = 2'd0,
      RD_LOADED = 2'd1,
      RD_TAIL   = 2'd2
   } rd_state_t;

   typedef enum logic {
      WR_IDLE = 1'b0,
      WR_TAIL = 1'b1
   } wr_state_t;

   localparam int unsigned LANES = 2;

   function automatic logic [1:0] lane_of(input logic [1:0] base, input logic [1:0] k);
      return base + k;
   endfunction

endpackage

// File: rtl/sio_burst4_store.sv
module sio_burst4_store #(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned DATA_W = 16
) (
   input  logic                                                 clk,
   input  logic                                                 rst,
   input  logic [sio_burst4_pkg::LANES-1:0]                     we,
   input  logic [sio_burst4_pkg::LANES-1:0][ADDR_W-1:0]         waddr,
   input  logic [sio_burst4_pkg::LANES-1:0][DATA_W-1:0]         wdata,
   input  logic [sio_burst4_pkg::LANES-1:0][ADDR_W-1:0]         raddr,
   output logic [sio_burst4_pkg::LANES-1:0][DATA_W-1:0]         rdata
);
   import sio_burst4_pkg::*;

   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] words [DEPTH];

   always_ff @(posedge clk) begin
      for (int w = 0; w < int'(LANES); w++) begin
         if (we[w]) words[waddr[w]] <= wdata[w];
      end
   end

   for (genvar p = 0; p < int'(LANES); p++) begin : g_rport
      always_comb begin
         rdata[p] = words[raddr[p]];
         for (int w = 0; w < int'(LANES); w++) begin
            if (we[w] && (waddr[w] == raddr[p])) rdata[p] = wdata[w];
         end
      end
   end

   // R5: the two lanes of one burst pair never land on the same word
   p_lane_distinct_r5: assert property (@(posedge clk) disable iff (rst)
      (we[0] && we[1]) |-> (waddr[0] != waddr[1]));

endmodule

// File: rtl/sio_burst4_rd_seq.sv
module sio_burst4_rd_seq #(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned DATA_W = 16
) (
   input  logic                                         clk,
   input  logic                                         rst,
   input  logic                                         rd_n,
   input  logic [ADDR_W-1:0]                            rd_addr,
   output logic [sio_burst4_pkg::LANES-1:0][ADDR_W-1:0] raddr,
   input  logic [sio_burst4_pkg::LANES-1:0][DATA_W-1:0] rdata,
   output logic                                         rd_valid,
   output logic [DATA_W-1:0]                            rd_lo,
   output logic [DATA_W-1:0]                            rd_hi,
   output logic                                         loaded
);
   import sio_burst4_pkg::*;

   rd_state_t         state;
   logic [ADDR_W-1:0] base;
   logic [1:0]        k0;

   assign loaded = (state == RD_LOADED);
   assign k0     = (state == RD_TAIL) ? 2'd2 : 2'd0;

   always_comb begin
      raddr[0] = {base[ADDR_W-1:2], lane_of(base[1:0], k0)};
      raddr[1] = {base[ADDR_W-1:2], lane_of(base[1:0], k0 + 2'd1)};
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state    <= RD_IDLE;
         base     <= '0;
         rd_valid <= 1'b0;
         rd_lo    <= '0;
         rd_hi    <= '0;
      end else begin
         case (state)
            RD_LOADED: begin
               rd_valid <= 1'b1;
               rd_lo    <= rdata[0];
               rd_hi    <= rdata[1];
               state    <= RD_TAIL;
            end
            RD_TAIL: begin
               rd_valid <= 1'b1;
               rd_lo    <= rdata[0];
               rd_hi    <= rdata[1];
               if (!rd_n) begin
                  state <= RD_LOADED;
                  base  <= rd_addr;
               end else begin
                  state <= RD_IDLE;
               end
            end
            default: begin
               rd_valid <= 1'b0;
               rd_lo    <= '0;
               rd_hi    <= '0;
               if (!rd_n) begin
                  state <= RD_LOADED;
                  base  <= rd_addr;
               end
            end
         endcase
      end
   end

   // R3: a load is never followed directly by another load
   p_load_gap_r3: assert property (@(posedge clk) disable iff (rst)
      (state == RD_LOADED) |=> (state != RD_LOADED));
   // R4: a loaded read yields a head pair, then a tail pair
   p_head_valid_r4: assert property (@(posedge clk) disable iff (rst)
      (state == RD_LOADED) |=> rd_valid);
   p_tail_valid_r4: assert property (@(posedge clk) disable iff (rst)
      (state == RD_TAIL) |=> rd_valid);
   // R9: an idle slot leaves the output marked not valid and zero
   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
      (state == RD_IDLE) |=> (!rd_valid && rd_lo == '0 && rd_hi == '0));

endmodule

// File: rtl/sio_burst4_wr_seq.sv
module sio_burst4_wr_seq #(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned DATA_W = 16
) (
   input  logic                                         clk,
   input  logic                                         rst,
   input  logic                                         wr_n,
   input  logic [ADDR_W-1:0]                            wr_addr,
   input  logic [DATA_W-1:0]                            wr_lo,
   input  logic [DATA_W-1:0]                            wr_hi,
   output logic [sio_burst4_pkg::LANES-1:0]             we,
   output logic [sio_burst4_pkg::LANES-1:0][ADDR_W-1:0] waddr,
   output logic [sio_burst4_pkg::LANES-1:0][DATA_W-1:0] wdata,
   output logic                                         tail
);
   import sio_burst4_pkg::*;

   wr_state_t         state;
   logic [ADDR_W-1:0] base;
   logic [ADDR_W-1:0] cur;
   logic [1:0]        k0;
   logic              fire;

   assign tail  = (state == WR_TAIL);
   assign fire  = !rst && (tail || !wr_n);
   assign cur   = tail ? base : wr_addr;
   assign k0    = tail ? 2'd2 : 2'd0;

   always_comb begin
      we       = {LANES{fire}};
      waddr[0] = {cur[ADDR_W-1:2], lane_of(cur[1:0], k0)};
      waddr[1] = {cur[ADDR_W-1:2], lane_of(cur[1:0], k0 + 2'd1)};
      wdata[0] = wr_lo;
      wdata[1] = wr_hi;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= WR_IDLE;
         base  <= '0;
      end else if (state == WR_TAIL) begin
         state <= WR_IDLE;
      end else if (!wr_n) begin
         state <= WR_TAIL;
         base  <= wr_addr;
      end
   end

   // R6: the second cycle of a write is always followed by a free slot
   p_tail_once_r6: assert property (@(posedge clk) disable iff (rst)
      (state == WR_TAIL) |=> (state == WR_IDLE));
   // R6: the tail lane stays in the base address group
   p_tail_group_r6: assert property (@(posedge clk) disable iff (rst)
      (state == WR_TAIL) |-> (waddr[0][ADDR_W-1:2] == $past(wr_addr[ADDR_W-1:2])));

endmodule

// File: rtl/sio_burst4_sram.sv
module sio_burst4_sram #(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rd_n,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              wr_n,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_lo,
   input  logic [DATA_W-1:0] wr_hi,
   output logic [DATA_W-1:0] rd_lo,
   output logic [DATA_W-1:0] rd_hi,
   output logic              rd_valid
);
   import sio_burst4_pkg::*;

   if (ADDR_W < 2) begin : g_bad_addr
      $error("ADDR_W must cover the two burst lane bits");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be at least one bit");
   end

   logic [LANES-1:0]             we;
   logic [LANES-1:0][ADDR_W-1:0] waddr;
   logic [LANES-1:0][DATA_W-1:0] wdata;
   logic [LANES-1:0][ADDR_W-1:0] raddr;
   logic [LANES-1:0][DATA_W-1:0] rdata;
   logic                         rd_loaded;
   logic                         wr_tail;

   sio_burst4_wr_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) wr_i (
      .clk(clk), .rst(rst), .wr_n(wr_n), .wr_addr(wr_addr),
      .wr_lo(wr_lo), .wr_hi(wr_hi),
      .we(we), .waddr(waddr), .wdata(wdata), .tail(wr_tail)
   );

   sio_burst4_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) store_i (
      .clk(clk), .rst(rst), .we(we), .waddr(waddr), .wdata(wdata),
      .raddr(raddr), .rdata(rdata)
   );

   sio_burst4_rd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) rd_i (
      .clk(clk), .rst(rst), .rd_n(rd_n), .rd_addr(rd_addr),
      .raddr(raddr), .rdata(rdata),
      .rd_valid(rd_valid), .rd_lo(rd_lo), .rd_hi(rd_hi), .loaded(rd_loaded)
   );

   // R1: reset leaves the output quiet on the next cycle
   p_reset_quiet_r1: assert property (@(posedge clk)
      rst |=> (!rd_valid && rd_lo == '0 && rd_hi == '0));
   // R2: a high command in a free slot starts nothing
   p_deselect_rd_r2: assert property (@(posedge clk) disable iff (rst)
      (rd_n && !rd_loaded) |=> !rd_loaded);
   p_deselect_wr_r2: assert property (@(posedge clk) disable iff (rst)
      (wr_n && !wr_tail) |=> !wr_tail);
   // R7: a write command in a free slot starts its burst whatever the read port does
   p_wr_indep_r7: assert property (@(posedge clk) disable iff (rst)
      (!wr_n && !wr_tail) |=> wr_tail);

endmodule

// File: tb/sio_burst4_sram_tb_top.sv
`timescale 1ns/100ps
module sio_burst4_sram_tb_top;
   localparam int AW = 6;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          rd_n = 1'b1;
   logic [AW-1:0] rd_addr = '0;
   logic          wr_n = 1'b1;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_lo = '0;
   logic [DW-1:0] wr_hi = '0;
   logic [DW-1:0] rd_lo;
   logic [DW-1:0] rd_hi;
   logic          rd_valid;

   int    n_checks = 0;
   int    n_fails  = 0;
   bit    done     = 1'b0;
   string cur_tag  = "R1";

   always #2.5 clk = ~clk;

   sio_burst4_sram #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
      .clk(clk), .rst(rst), .rd_n(rd_n), .rd_addr(rd_addr),
      .wr_n(wr_n), .wr_addr(wr_addr), .wr_lo(wr_lo), .wr_hi(wr_hi),
      .rd_lo(rd_lo), .rd_hi(rd_hi), .rd_valid(rd_valid)
   );

   function automatic logic [AW-1:0] baddr(input logic [AW-1:0] a, input int k);
      logic [1:0] l;
      l = a[1:0] + k[1:0];
      return {a[AW-1:2], l};
   endfunction

   function automatic logic [DW-1:0] pat(input int i);
      return DW'(16'h5A00 ^ (i * 771));
   endfunction

   // reference model and scoreboard
   logic [DW-1:0] mem_m [64];
   int            m_rph = 0;
   logic [AW-1:0] m_rbase = '0;
   string         m_rtag = "";
   bit            m_wtail = 1'b0;
   logic [AW-1:0] m_wbase = '0;
   bit            m_rv = 1'b0;
   bit            m_seen = 1'b0;
   logic [DW-1:0] q_lo [$];
   logic [DW-1:0] q_hi [$];
   string         q_tag [$];

   always @(posedge clk) begin
      m_seen = 1'b1;
      m_rv   = 1'b0;
      if (rst) begin
         m_rph   = 0;
         m_wtail = 1'b0;
      end else begin
         if (m_wtail) begin
            mem_m[baddr(m_wbase, 2)] = wr_lo;
            mem_m[baddr(m_wbase, 3)] = wr_hi;
            m_wtail = 1'b0;
         end else if (!wr_n) begin
            mem_m[baddr(wr_addr, 0)] = wr_lo;
            mem_m[baddr(wr_addr, 1)] = wr_hi;
            m_wbase = wr_addr;
            m_wtail = 1'b1;
         end
         if (m_rph != 0) begin
            m_rv = 1'b1;
            q_lo.push_back(mem_m[baddr(m_rbase, (m_rph == 2) ? 2 : 0)]);
            q_hi.push_back(mem_m[baddr(m_rbase, (m_rph == 2) ? 3 : 1)]);
            q_tag.push_back(m_rtag);
         end
         if (m_rph == 1) m_rph = 2;
         else if (!rd_n) begin
            m_rph   = 1;
            m_rbase = rd_addr;
            m_rtag  = cur_tag;
         end else m_rph = 0;
      end
   end

   always @(negedge clk) begin
      if (m_seen && !done) begin
         logic [DW-1:0] el, eh;
         string t;
         n_checks++;
         if (rd_valid !== m_rv) begin
            n_fails++;
            $display("FAIL %s rd_valid actual=%b expected=%b", cur_tag, rd_valid, m_rv);
         end
         if (m_rv) begin
            el = q_lo.pop_front();
            eh = q_hi.pop_front();
            t  = q_tag.pop_front();
            if (rd_lo !== el || rd_hi !== eh) begin
               n_fails++;
               $display("FAIL %s pair actual=%h/%h expected=%h/%h", t, rd_lo, rd_hi, el, eh);
            end
         end else if (rd_lo !== '0 || rd_hi !== '0) begin
            n_fails++;
            $display("FAIL R9 idle data actual=%h/%h expected=0000/0000", rd_lo, rd_hi);
         end
      end
   end

   task automatic step(input logic rn, input logic [AW-1:0] ra, input logic wn,
                       input logic [AW-1:0] wa, input logic [DW-1:0] lo, input logic [DW-1:0] hi);
      @(negedge clk);
      rd_n = rn; rd_addr = ra; wr_n = wn; wr_addr = wa; wr_lo = lo; wr_hi = hi;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b1, '0, 1'b1, '0, '0, '0);
   endtask

   task automatic rd(input logic [AW-1:0] a);
      step(1'b0, a, 1'b1, '0, '0, '0);
   endtask

   initial begin
      for (int i = 0; i < 64; i++) mem_m[i] = '0;
      repeat (3) @(negedge clk);
      // R1: output quiet while reset is held
      n_checks++;
      if (rd_valid !== 1'b0 || rd_lo !== '0 || rd_hi !== '0) begin
         n_fails++;
         $display("FAIL R1 reset actual=%b %h %h expected=0 0000 0000", rd_valid, rd_lo, rd_hi);
      end
      rst = 1'b0;

      cur_tag = "R6";
      for (int b = 0; b < 16; b++) begin
         step(1'b1, '0, 1'b0, AW'(4 * b), pat(4 * b), pat(4 * b + 1));
         step(1'b1, '0, 1'b1, '0, pat(4 * b + 2), pat(4 * b + 3));
      end
      idle(2);

      cur_tag = "R2";
      step(1'b1, '0, 1'b1, 6'h00, 16'hDEAD, 16'hBEEF);
      step(1'b1, '0, 1'b1, 6'h02, 16'hDEAD, 16'hBEEF);
      rd(6'h00); idle(3);

      cur_tag = "R4";
      rd(6'h08); idle(1); rd(6'h10); idle(1); rd(6'h2C); idle(3);

      cur_tag = "R3";
      rd(6'h04); rd(6'h30); rd(6'h14); rd(6'h38); rd(6'h1C); idle(4);

      cur_tag = "R5";
      rd(6'h05); idle(1); rd(6'h0B); idle(1); rd(6'h3E); idle(3);

      cur_tag = "R6";
      step(1'b1, '0, 1'b0, 6'h20, 16'h1111, 16'h2222);
      step(1'b1, '0, 1'b0, 6'h30, 16'h3333, 16'h4444);
      idle(1); rd(6'h20); idle(1); rd(6'h30); idle(3);

      cur_tag = "R7";
      step(1'b0, 6'h14, 1'b0, 6'h24, 16'hA1A1, 16'hA2A2);
      step(1'b1, '0, 1'b1, '0, 16'hA3A3, 16'hA4A4);
      idle(1); rd(6'h24); idle(3);

      cur_tag = "R8";
      step(1'b0, 6'h1A, 1'b0, 6'h18, 16'hC0C0, 16'hC1C1);
      step(1'b1, '0, 1'b1, '0, 16'hC2C2, 16'hC3C3);
      idle(1);
      rd(6'h0D);
      step(1'b1, '0, 1'b0, 6'h0C, 16'hE0E0, 16'hE1E1);
      step(1'b1, '0, 1'b1, '0, 16'hE2E2, 16'hE3E3);
      idle(3);

      cur_tag = "R9";
      rd(6'h18); idle(4);

      cur_tag = "R1";
      step(1'b0, 6'h28, 1'b0, 6'h34, 16'h7777, 16'h7777);
      rst = 1'b1;
      step(1'b1, '0, 1'b1, '0, 16'h8888, 16'h8888);
      idle(1);
      rst = 1'b0;
      rd(6'h34); idle(4);

      done = 1'b1;
      if (q_lo.size() != 0) begin
         n_fails++;
         $display("FAIL R4 leftover pairs actual=%0d expected=0", q_lo.size());
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end
endmodule